// File: doc/BRIEF.md
# Grouped Interrupt Vector Aggregator

This block gathers a wide set of edge-type interrupt sources into a vector controller and presents one upstream interrupt line for each group of 32 sources. A rising edge on a source latches a pending bit. Software masks or unmasks each vector through an enable word. It acknowledges a vector by writing a one to that vector's pending bit. Each upstream line is raised while its group has at least one vector that is both pending and enabled.

Control is through a plain 32-bit register port that uses byte addresses and whole-word accesses. The number of groups is a parameter (`NUM_GROUPS`, 1 to 8, so up to 256 vectors). Source lines are sampled synchronously on the block clock. The register port has no back-pressure: a write takes effect at the clock edge where `reg_wr_en` is high. A read strobe returns its data with `reg_rvalid` on the next cycle. Issuing reads back to back is allowed, and every read is answered.

Top module: `irq_vector_agg`

## Requirements
- R1: Vector n belongs to group n/32 at bit n%32. The pending word of group g is at byte address 4*g, and the enable word of group g is at byte address 0x20 + 4*g.
- R2: A source sampled low at one clock edge and high at the next sets its pending bit at that second edge. A source held high sets nothing more after its bit has been cleared.
- R3: A register write to a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a rising edge and a clearing write hit the same pending bit at the same clock edge, the bit ends up set.
- R5: Enable words are read/write over all 32 bits. A 1 unmasks a vector and a 0 masks it, and an enable word changes only when it is written.
- R6: `irq_out[g]` is high exactly when the pending word and the enable word of group g share a set bit. It follows any register update in the same cycle, without an extra clock of delay.
- R7: Pending bits latch while their vector is masked, and a read of a pending word returns its raw value regardless of enables.
- R8: After reset every pending and enable bit is 0 and every `irq_out` line is low. A source that is already high when reset is released does not count as an edge.
- R9: An address is unmapped if its two low bits are not zero, if it is 0x40 or above, or if it selects a group at or beyond `NUM_GROUPS`. Reads at an unmapped address return 0, and writes to one change no register.
- R10: `reg_rvalid` is high for exactly the one cycle after a cycle with `reg_rd_en` high, and `reg_rdata` then holds the addressed word as it was before any write made in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_GROUPS*32 | Interrupt source levels, vector n on bit n |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| irq_out | output | NUM_GROUPS | Upstream interrupt line per group |

## Verification
The assertions check several rules on every cycle. A pending bit stays set until a write-one reaches it, a captured edge always survives into the pending word, no pending bit appears without an edge, and enable words hold still unless they are written. They also check that unmapped reads come back as zero and that each read strobe gets exactly one valid cycle. The bench scenarios are needed to show the address map and the placement of vectors, and that the upstream lines combine pending with enable for each group. They also show that a source held high through reset does not count as an edge, that unmapped writes leave real registers untouched, and that a read ordered with a write in the same cycle returns the value from before the write.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // Vectors carried by one group word
  localparam int LANE = 32;
  // Upper bound on groups; addresses stop at 0x40
  localparam int MAX_GROUPS = 8;
  // Byte address where the enable bank starts
  localparam int EN_BANK_BASE = 32'h20;

  typedef enum logic [1:0] {
    BANK_PEND = 2'd0,
    BANK_EN   = 2'd1,
    BANK_NONE = 2'd2
  } bank_e;

  typedef struct packed {
    bank_e      bank;
    logic [2:0] grp;
  } reg_sel_t;
endpackage

// File: rtl/irqv_edge.sv
module irqv_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  // Reset to all ones: a level already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= src;
  end

  assign rise = src & ~prev_q;
endmodule

// File: rtl/irqv_group.sv
module irqv_group #(
  parameter int LANE = irqv_pkg::LANE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LANE-1:0] rise,
  input  logic [LANE-1:0] clr,
  input  logic            en_we,
  input  logic [LANE-1:0] en_wdata,
  output logic [LANE-1:0] pend,
  output logic [LANE-1:0] en,
  output logic            irq
);
  logic [LANE-1:0] pend_q, en_q, pend_d;

  // Edge wins over a clearing write that lands on the same bit
  assign pend_d = (pend_q & ~clr) | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign irq  = |(pend_q & en_q);

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

  // R4
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & ~pend) == '0));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(rise)) == '0));

  // R5
  en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en));
endmodule

// File: rtl/irqv_regport.sv
module irqv_regport
  import irqv_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [LANE-1:0]                  wdata,
  input  logic [NUM_GROUPS-1:0][LANE-1:0]  pend,
  input  logic [NUM_GROUPS-1:0][LANE-1:0]  en,
  output logic [NUM_GROUPS-1:0][LANE-1:0]  clr,
  output logic [NUM_GROUPS-1:0]            en_we,
  output logic [LANE-1:0]                  rdata,
  output logic                             rvalid
);
  reg_sel_t        sel;
  logic [LANE-1:0] rd_word;
  logic [LANE-1:0] rdata_q;
  logic            rvalid_q;
  logic            aligned, in_window, grp_ok;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    in_window = (addr[ADDR_W-1:6] == '0);
    grp_ok    = (int'(addr[4:2]) < NUM_GROUPS);
    sel.grp   = addr[4:2];
    if (aligned && in_window && grp_ok)
      sel.bank = addr[5] ? BANK_EN : BANK_PEND;
    else
      sel.bank = BANK_NONE;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_strobe
    logic hit;
    assign hit      = (sel.grp == 3'(g));
    assign clr[g]   = (wr_en && hit && sel.bank == BANK_PEND) ? wdata : '0;
    assign en_we[g] = wr_en && hit && (sel.bank == BANK_EN);
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel.grp == 3'(g)) begin
        if (sel.bank == BANK_PEND)    rd_word = pend[g];
        else if (sel.bank == BANK_EN) rd_word = en[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R9
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel.bank == BANK_NONE) |=> (rdata == '0));

  // R10
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

// File: rtl/irq_vector_agg.sv
module irq_vector_agg
  import irqv_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GROUPS*32-1:0]   src_in,
  input  logic                       reg_wr_en,
  input  logic                       reg_rd_en,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       reg_rvalid,
  output logic [NUM_GROUPS-1:0]      irq_out
);
  localparam int NVEC = NUM_GROUPS * LANE;

  logic [NVEC-1:0]                 rise;
  logic [NUM_GROUPS-1:0][LANE-1:0] pend, en, clr;
  logic [NUM_GROUPS-1:0]           en_we;

  irqv_edge #(.W(NVEC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (src_in),
    .rise (rise)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqv_group #(.LANE(LANE)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise[g*LANE +: LANE]),
      .clr     (clr[g]),
      .en_we   (en_we[g]),
      .en_wdata(reg_wdata),
      .pend    (pend[g]),
      .en      (en[g]),
      .irq     (irq_out[g])
    );
  end

  irqv_regport #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .rd_en (reg_rd_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .pend  (pend),
    .en    (en),
    .clr   (clr),
    .en_we (en_we),
    .rdata (reg_rdata),
    .rvalid(reg_rvalid)
  );
endmodule

// File: tb/test_irq_vector_agg.sv
module test_irq_vector_agg;
  localparam int NG = 4;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NG*32-1:0] src_in;
  logic            reg_wr_en, reg_rd_en;
  logic [AW-1:0]   reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic            reg_rvalid;
  logic [NG-1:0]   irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_vector_agg #(.NUM_GROUPS(NG), .ADDR_W(AW)) i_irq_vector_agg (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic pulse_src(int n);
    @(negedge clk); src_in[n] = 1'b1;
    @(negedge clk); src_in[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int g = 0; g < NG; g++) begin
      bus_read(8'(4*g), d);        check("R8 pend after reset", d, 32'h0);
      bus_read(8'(32 + 4*g), d);   check("R8 en after reset", d, 32'h0);
    end
    check("R8 irq after reset", 32'(irq_out), 32'h0);
    @(negedge clk); src_in[5] = 1'b0;
    @(negedge clk);
    bus_read(8'h00, d);            check("R8 level high at reset is no edge", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    pulse_src(37);
    pulse_src(100);
    bus_read(8'h04, d); check("R1 vector 37 in group 1 bit 5", d, 32'h20);
    bus_read(8'h0C, d); check("R1 vector 100 in group 3 bit 4", d, 32'h10);
    bus_read(8'h08, d); check("R2 no edge group 2", d, 32'h0);
    check("R7 masked pending keeps irq low", 32'(irq_out), 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_write(8'h24, 32'hFFFF_FFFF);
    check("R6 irq group 1 after enable", 32'(irq_out), 32'h2);
    bus_read(8'h24, d); check("R5 enable readback", d, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'h0000_0010);
    check("R6 irq groups 1 and 3", 32'(irq_out), 32'hA);
    bus_write(8'h24, 32'h0);
    check("R6 irq drops when masked", 32'(irq_out), 32'h8);
    bus_read(8'h04, d); check("R7 raw pending while masked", d, 32'h20);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(8'h0C, 32'hFFFF_FFEF);
    bus_read(8'h0C, d); check("R3 zero bit leaves pending", d, 32'h10);
    bus_write(8'h0C, 32'h0000_0010);
    check("R3 clear drops irq", 32'(irq_out), 32'h0);
    bus_read(8'h0C, d); check("R3 pending cleared", d, 32'h0);
    @(negedge clk); src_in[64] = 1'b1;
    @(negedge clk);
    bus_write(8'h08, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(8'h08, d); check("R2 held level does not re-set", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    src_in[65] = 1'b1;
    reg_wr_en = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h2;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
    bus_read(8'h08, d); check("R4 edge beats same-cycle clear", d, 32'h2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(8'h34, 32'hFFFF_FFFF);
    bus_read(8'h34, d);  check("R9 enable of absent group reads 0", d, 32'h0);
    bus_read(8'h14, d);  check("R9 pending of absent group reads 0", d, 32'h0);
    bus_read(8'h44, d);  check("R9 address above window reads 0", d, 32'h0);
    bus_write(8'h21, 32'hFFFF_FFFF);
    bus_read(8'h20, d);  check("R9 misaligned write ignored", d, 32'h0);
    bus_write(8'h49, 32'hFFFF_FFFF);
    bus_read(8'h08, d);  check("R9 out-of-window write ignored", d, 32'h2);
    check("R9 irq unchanged", 32'(irq_out), 32'h0);
  endtask

  task automatic t_rd_timing();
    logic [31:0] d;
    bus_write(8'h20, 32'h1234_5678);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_wr_en = 1'b1; reg_addr = 8'h20; reg_wdata = 32'hCAFE_0000;
    @(posedge clk); #1;
    reg_rd_en = 1'b0; reg_wr_en = 1'b0;
    check("R10 rvalid after strobe", 32'(reg_rvalid), 32'h1);
    check("R10 read sees value before write", reg_rdata, 32'h1234_5678);
    @(posedge clk); #1;
    check("R10 rvalid single cycle", 32'(reg_rvalid), 32'h0);
    bus_read(8'h20, d); check("R5 enable write landed", d, 32'hCAFE_0000);
  endtask

  initial begin
    rst_n = 1'b0; src_in = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    src_in[5] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_layout();
    t_enable();
    t_clear();
    t_race();
    t_unmapped();
    t_rd_timing();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule